// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading a two-level page table from memory. The address splits into an upper 10-bit directory index, a middle 10-bit table index and a 12-bit byte offset within a 4 KB page. Each table holds 1024 four-byte entries. A base input gives the frame of the directory table, and a length input bounds the 20-bit page number.

A request is accepted only while the walker is idle. It first checks the page number against the length limit. If that passes, it reads the directory entry and then the leaf entry, one after the other, over a request/valid memory port. It then reports either the physical address or a fault code. Entry layout: bits [31:12] hold a frame number. Bit 0 is valid, bit 1 allows reads, bit 2 allows writes and bit 3 allows execution. Bits [11:4] are ignored. The base and length inputs are sampled when a request is accepted, so a context switch only needs to change them while the walker is idle.

Top module: `pt_walker`

## Requirements
- R1: `req_ready_o` is high only while idle. A request is taken when `req_valid_i` and `req_ready_o` are both high. Requests raised while busy are ignored and produce no result and no memory read.
- R2: If the page number `vaddr[31:12]` is greater than or equal to `ptlr_i`, the result is fault code 1 (length). No memory read is made, and `done_o` is high in the cycle after acceptance.
- R3: The first read goes to address `{ptbr_i, vaddr[31:22], 2'b00}`, using the `ptbr_i` value sampled at acceptance.
- R4: The second read goes to address `{dir_entry[31:12], vaddr[21:12], 2'b00}`.
- R5: `mem_req_o` stays high with a stable `mem_addr_o` until a cycle with `mem_rvalid_i` high. `mem_rdata_i` is taken in that cycle.
- R6: A directory entry with bit 0 clear gives fault code 2, and no second read is made.
- R7: A leaf entry with bit 0 clear gives fault code 3. This takes priority over a permission fault.
- R8: Access codes are 0 = read (needs bit 1), 1 = write (needs bit 2), 2 = execute (needs bit 3) and 3 = reserved (always fails). If the needed bit is clear in a valid leaf entry, the result is fault code 4. A write to a read-only page therefore faults.
- R9: On success, the fault code is 0 and `pa_o = {leaf_entry[31:12], vaddr[11:0]}`.
- R10: `done_o` is a one-cycle pulse in the cycle after the last accepted read response. `req_ready_o` is high again in the following cycle.
- R11: After reset, `req_ready_o` is high and both `done_o` and `mem_req_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request |
| req_ready_o | output | 1 | Walker idle, request can be taken |
| req_vaddr_i | input | 32 | Virtual address |
| req_acc_i | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| ptbr_i | input | 20 | Frame number of the directory table |
| ptlr_i | input | 21 | Number of legal page numbers |
| mem_req_o | output | 1 | Memory read request, held until response |
| mem_addr_o | output | 32 | Byte address of the entry read |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data |
| done_o | output | 1 | Result pulse |
| pa_o | output | 32 | Physical address, zero on fault |
| fault_o | output | 3 | 0 none, 1 length, 2 bad directory entry, 3 bad leaf entry, 4 permission |

## Verification
A length fault is due exactly one cycle after the accepting edge. Every other result is due one cycle after the edge that takes the final read response. The bench's memory model records the cycle number at which it raises `mem_rvalid_i`, and the driver records the cycle at which it presents a request. When `done_o` appears, the monitor compares the current cycle with the recorded cycle plus one. The model also checks each read address and its stability while the response is withheld, with response latencies from zero to six cycles.

// File: rtl/pt_walker_pkg.sv
`timescale 1ns/1ps
package pt_walker_pkg;
  typedef enum logic [2:0] {
    FLT_NONE    = 3'd0,
    FLT_LEN     = 3'd1,
    FLT_DIR_INV = 3'd2,
    FLT_LEAF_INV = 3'd3,
    FLT_PERM    = 3'd4
  } fault_e;

  typedef enum logic [1:0] {
    ACC_RD  = 2'd0,
    ACC_WR  = 2'd1,
    ACC_EX  = 2'd2,
    ACC_RSV = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_DIR  = 2'd1,
    S_LEAF = 2'd2,
    S_DONE = 2'd3
  } walk_state_e;

  localparam int PTE_BIT_V  = 0;
  localparam int PTE_BIT_R  = 1;
  localparam int PTE_BIT_WR = 2;
  localparam int PTE_BIT_X  = 3;
  localparam int PTE_FLAGS  = 4;
endpackage

// File: rtl/ptw_addr_gen.sv
`timescale 1ns/1ps
module ptw_addr_gen #(
  parameter int IDX_W = 10,
  parameter int FRM_W = 20,
  parameter int PA_W  = 32,
  parameter int ENT_LSB = 2,
  localparam int VPN_W = 2 * IDX_W,
  localparam int LVLS  = 2
) (
  input  logic             leaf_i,
  input  logic [FRM_W-1:0] base_frm_i,
  input  logic [FRM_W-1:0] tbl_frm_i,
  input  logic [VPN_W-1:0] vpn_i,
  input  logic [VPN_W:0]   len_i,
  output logic [PA_W-1:0]  addr_o,
  output logic             len_ok_o
);
  logic [IDX_W-1:0] lvl_idx [LVLS];

  // level 0 takes the upper index, level 1 the lower
  for (genvar l = 0; l < LVLS; l++) begin : g_lvl
    assign lvl_idx[l] = vpn_i[(LVLS-1-l)*IDX_W +: IDX_W];
  end

  always_comb begin
    if (leaf_i) addr_o = PA_W'({tbl_frm_i, lvl_idx[1], {ENT_LSB{1'b0}}});
    else        addr_o = PA_W'({base_frm_i, lvl_idx[0], {ENT_LSB{1'b0}}});
  end

  assign len_ok_o = {1'b0, vpn_i} < len_i;
endmodule

// File: rtl/ptw_pte_check.sv
`timescale 1ns/1ps
module ptw_pte_check
  import pt_walker_pkg::*;
#(
  parameter int PTE_W = 32,
  parameter int FRM_W = 20,
  parameter int ACC_W = 2
) (
  input  logic [PTE_W-1:0] pte_i,
  input  logic [ACC_W-1:0] acc_i,
  output logic             valid_o,
  output logic             perm_ok_o,
  output logic [FRM_W-1:0] frame_o
);
  logic unused_bits;
  acc_e acc_sel;

  assign unused_bits = ^pte_i[PTE_W-FRM_W-1:PTE_FLAGS];
  assign valid_o     = pte_i[PTE_BIT_V];
  assign frame_o     = pte_i[PTE_W-1 -: FRM_W];
  assign acc_sel     = acc_e'(acc_i);

  always_comb begin
    unique case (acc_sel)
      ACC_RD:  perm_ok_o = pte_i[PTE_BIT_R];
      ACC_WR:  perm_ok_o = pte_i[PTE_BIT_WR];
      ACC_EX:  perm_ok_o = pte_i[PTE_BIT_X];
      default: perm_ok_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/pt_walker.sv
`timescale 1ns/1ps
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int IDX_W = 10,
  parameter int OFF_W = 12,
  parameter int PTE_W = 32,
  parameter int ACC_W = 2,
  parameter int FLT_W = 3,
  localparam int FRM_W = VA_W - OFF_W,
  localparam int VPN_W = 2 * IDX_W,
  localparam int PA_W  = FRM_W + OFF_W,
  localparam int ENT_LSB = OFF_W - IDX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [VA_W-1:0]  req_vaddr_i,
  input  logic [ACC_W-1:0] req_acc_i,
  input  logic [FRM_W-1:0] ptbr_i,
  input  logic [VPN_W:0]   ptlr_i,
  output logic             mem_req_o,
  output logic [PA_W-1:0]  mem_addr_o,
  input  logic             mem_rvalid_i,
  input  logic [PTE_W-1:0] mem_rdata_i,
  output logic             done_o,
  output logic [PA_W-1:0]  pa_o,
  output logic [FLT_W-1:0] fault_o
);
  walk_state_e      state_q;
  logic [VA_W-1:0]  va_q;
  logic [ACC_W-1:0] acc_q;
  logic [FRM_W-1:0] base_q, tbl_q;
  logic [PA_W-1:0]  pa_q;
  logic [FLT_W-1:0] flt_q;
  logic [VPN_W-1:0] vpn_sel;
  logic             len_ok, pte_v, pte_perm;
  logic [FRM_W-1:0] pte_frm;

  // length check uses the incoming address while idle
  assign vpn_sel = (state_q == S_IDLE) ? req_vaddr_i[VA_W-1:OFF_W] : va_q[VA_W-1:OFF_W];

  ptw_addr_gen #(
    .IDX_W(IDX_W), .FRM_W(FRM_W), .PA_W(PA_W), .ENT_LSB(ENT_LSB)
  ) u_addr_gen (
    .leaf_i    (state_q == S_LEAF),
    .base_frm_i(base_q),
    .tbl_frm_i (tbl_q),
    .vpn_i     (vpn_sel),
    .len_i     (ptlr_i),
    .addr_o    (mem_addr_o),
    .len_ok_o  (len_ok)
  );

  ptw_pte_check #(
    .PTE_W(PTE_W), .FRM_W(FRM_W), .ACC_W(ACC_W)
  ) u_pte_check (
    .pte_i    (mem_rdata_i),
    .acc_i    (acc_q),
    .valid_o  (pte_v),
    .perm_ok_o(pte_perm),
    .frame_o  (pte_frm)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      va_q    <= '0;
      acc_q   <= '0;
      base_q  <= '0;
      tbl_q   <= '0;
      pa_q    <= '0;
      flt_q   <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (req_valid_i) begin
          va_q   <= req_vaddr_i;
          acc_q  <= req_acc_i;
          base_q <= ptbr_i;
          if (len_ok) state_q <= S_DIR;
          else begin
            flt_q   <= FLT_W'(FLT_LEN);
            pa_q    <= '0;
            state_q <= S_DONE;
          end
        end
        S_DIR: if (mem_rvalid_i) begin
          if (pte_v) begin
            tbl_q   <= pte_frm;
            state_q <= S_LEAF;
          end else begin
            flt_q   <= FLT_W'(FLT_DIR_INV);
            pa_q    <= '0;
            state_q <= S_DONE;
          end
        end
        S_LEAF: if (mem_rvalid_i) begin
          state_q <= S_DONE;
          if (!pte_v) begin
            flt_q <= FLT_W'(FLT_LEAF_INV);
            pa_q  <= '0;
          end else if (!pte_perm) begin
            flt_q <= FLT_W'(FLT_PERM);
            pa_q  <= '0;
          end else begin
            flt_q <= FLT_W'(FLT_NONE);
            pa_q  <= {pte_frm, va_q[OFF_W-1:0]};
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign req_ready_o = (state_q == S_IDLE);
  assign mem_req_o   = (state_q == S_DIR) || (state_q == S_LEAF);
  assign done_o      = (state_q == S_DONE);
  assign pa_o        = pa_q;
  assign fault_o     = flt_q;

  assert_busy_after_accept_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> !req_ready_o);

  assert_len_fault_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o && ({1'b0, req_vaddr_i[VA_W-1:OFF_W]} >= ptlr_i)
    |=> done_o && fault_o == FLT_W'(FLT_LEN) && !mem_req_o);

  assert_req_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_rvalid_i |=> mem_req_o && $stable(mem_addr_o));

  assert_fault_range_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> fault_o <= FLT_W'(FLT_PERM));

  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && req_ready_o);

  assert_idle_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !mem_req_o && !done_o);
endmodule

// File: tb/pt_walker_bench.sv
`timescale 1ns/1ps
module pt_walker_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid, req_ready, mem_req, mem_rvalid, done;
  logic [31:0] req_vaddr, mem_addr, mem_rdata, pa;
  logic [1:0]  req_acc;
  logic [19:0] ptbr;
  logic [20:0] ptlr;
  logic [2:0]  fault;

  always #2.5 clk_i = ~clk_i;

  pt_walker u_pt_walker (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_vaddr_i(req_vaddr), .req_acc_i(req_acc),
    .ptbr_i(ptbr), .ptlr_i(ptlr),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .done_o(done), .pa_o(pa), .fault_o(fault)
  );

  typedef struct {
    logic [2:0]  f;
    logic [31:0] pa;
    int          n;
    string       tag;
  } exp_t;

  exp_t        exp_q[$];
  logic [31:0] addr_q[$];
  logic [31:0] mem [logic [31:0]];
  int n_chk = 0, n_fail = 0, cyc = 0, ev_cyc = 0, rd_cnt = 0, lat = 0;
  bit finished = 0;

  always @(posedge clk_i) cyc <= cyc + 1;

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  // driver: expected reads and result go to queues, then request is presented
  task automatic walk(input logic [31:0] va, input logic [1:0] acc, input logic [2:0] f,
                      input logic [31:0] epa, input int n, input string tag);
    exp_t e;
    logic [31:0] a1, d;
    a1 = {ptbr, va[31:22], 2'b00};
    d  = rd(a1);
    if (n >= 1) addr_q.push_back(a1);
    if (n >= 2) addr_q.push_back({d[31:12], va[21:12], 2'b00});
    e.f = f; e.pa = epa; e.n = n; e.tag = tag;
    exp_q.push_back(e);
    while (!req_ready) @(negedge clk_i);
    req_valid = 1'b1; req_vaddr = va; req_acc = acc; ev_cyc = cyc;
    @(negedge clk_i);
    req_valid = 1'b0;
    while (exp_q.size() != 0) @(negedge clk_i);
    @(negedge clk_i);
  endtask

  // memory model: checks address and its hold, answers after lat cycles (R3, R4, R5)
  initial begin
    logic [31:0] ra, ea;
    bit held;
    mem_rvalid = 1'b0;
    mem_rdata  = '0;
    forever begin
      @(negedge clk_i);
      if (rst_ni && mem_req) begin
        ra = mem_addr;
        rd_cnt++;
        if (addr_q.size() == 0) chk(0, "R1", "unexpected read", ra, 32'h0);
        else begin
          ea = addr_q.pop_front();
          chk(ra == ea, "R3/R4", "read address", ra, ea);
        end
        held = 1;
        for (int i = 0; i < lat; i++) begin
          @(negedge clk_i);
          if (!(mem_req && mem_addr == ra)) held = 0;
        end
        if (lat > 0) chk(held, "R5", "request hold", {31'b0, held}, 32'h1);
        mem_rdata = rd(ra); mem_rvalid = 1'b1; ev_cyc = cyc;
        @(negedge clk_i);
        mem_rvalid = 1'b0;
      end
    end
  end

  // monitor: compares each result with the scoreboard head
  initial begin
    exp_t e;
    forever begin
      @(negedge clk_i);
      if (rst_ni && done) begin
        if (exp_q.size() == 0) chk(0, "R1", "unexpected done", {29'b0, fault}, 32'h0);
        else begin
          e = exp_q.pop_front();
          chk(fault == e.f, e.tag, "fault", {29'b0, fault}, {29'b0, e.f});
          if (e.f == 3'd0) chk(pa == e.pa, e.tag, "pa", pa, e.pa);
          chk(rd_cnt == e.n, e.tag, "read count", rd_cnt, e.n);
          chk(cyc == ev_cyc + 1, "R10", "done timing", cyc, ev_cyc + 1);
        end
        rd_cnt = 0;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL R10 watchdog: actual timeout expected done");
    finish_run();
  end

  initial begin
    req_valid = 0; req_vaddr = '0; req_acc = '0;
    ptbr = 20'h00100; ptlr = 21'h100000;
    // directory at frame 0x00100, leaf table at frame 0x00200
    mem[32'h0010_000C] = 32'h0020_0001;
    mem[32'h0010_0014] = 32'h0030_0000;
    mem[32'h0020_001C] = 32'h1234_5007;
    mem[32'h0020_0020] = 32'h0ABC_D003;
    mem[32'h0020_0024] = 32'h0077_7009;
    mem[32'h0020_0028] = 32'h5555_5006;
    mem[32'h0040_000C] = 32'h0050_0001;
    mem[32'h0050_001C] = 32'hABCD_E003;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(req_ready == 1'b1, "R11", "ready after reset", {31'b0, req_ready}, 32'h1);
    chk(done == 1'b0, "R11", "done after reset", {31'b0, done}, 32'h0);
    chk(mem_req == 1'b0, "R11", "mem_req after reset", {31'b0, mem_req}, 32'h0);

    lat = 0; walk(32'h00C0_7ABC, 2'd0, 3'd0, 32'h1234_5ABC, 2, "R9");
    lat = 3; walk(32'h00C0_7ABC, 2'd1, 3'd0, 32'h1234_5ABC, 2, "R9");
    lat = 1; walk(32'h00C0_7ABC, 2'd2, 3'd4, 32'h0, 2, "R8");
    walk(32'h00C0_8123, 2'd1, 3'd4, 32'h0, 2, "R8");
    walk(32'h00C0_8123, 2'd0, 3'd0, 32'h0ABC_D123, 2, "R9");
    lat = 2; walk(32'h00C0_9010, 2'd2, 3'd0, 32'h0077_7010, 2, "R8");
    walk(32'h00C0_9010, 2'd0, 3'd4, 32'h0, 2, "R8");
    walk(32'h00C0_7ABC, 2'd3, 3'd4, 32'h0, 2, "R8");
    walk(32'h00C0_A000, 2'd0, 3'd3, 32'h0, 2, "R7");
    lat = 0; walk(32'h0140_0044, 2'd0, 3'd2, 32'h0, 1, "R6");
    walk(32'h0180_1000, 2'd0, 3'd2, 32'h0, 1, "R6");

    ptlr = 21'h000C08;
    walk(32'h00C0_7ABC, 2'd0, 3'd0, 32'h1234_5ABC, 2, "R2");
    walk(32'h00C0_8123, 2'd0, 3'd1, 32'h0, 0, "R2");
    ptlr = 21'h0;
    walk(32'h0000_0000, 2'd0, 3'd1, 32'h0, 0, "R2");
    ptlr = 21'h100000;

    // request raised while busy must be ignored
    lat = 6;
    fork
      walk(32'h00C0_7ABC, 2'd0, 3'd0, 32'h1234_5ABC, 2, "R1");
      begin
        repeat (2) @(negedge clk_i);
        req_valid = 1'b1; req_vaddr = 32'h00C0_8123; req_acc = 2'd0;
        repeat (4) @(negedge clk_i);
        req_valid = 1'b0;
      end
    join
    repeat (10) @(negedge clk_i);
    chk(exp_q.size() == 0 && addr_q.size() == 0, "R1", "no stray activity",
        exp_q.size() + addr_q.size(), 32'h0);

    // context switch: new directory base
    lat = 1; ptbr = 20'h00400;
    walk(32'h00C0_7ABC, 2'd0, 3'd0, 32'hABCD_EABC, 2, "R3");

    repeat (5) @(negedge clk_i);
    finish_run();
  end
endmodule